// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block arbitrates sixteen interrupt request lines for a small processor core. A rising edge on a request line sets a pending flag for that source. Each source has an enable bit and a two-bit priority level. An enabled pending source may be dispatched only if its level is strictly above the level now in service. When such a source exists, the block raises a vector request to the core. The request carries the source index, its level and a handler address computed from the index.

The core accepts a vector by pulsing its instruction-complete input while the request is high. On that clock edge the winning source's pending flag clears and its level is marked in service. The in-service state is a mask with one bit per level, so handlers can nest up to four deep. A return pulse from the core clears the highest marked level. Requests that were held back by that level then become eligible again.

Software sets up enables and levels through a small 8-bit register port. The port has eight addresses, and its read data is combinational.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every configuration register reads 0x00, no source is pending, `svc_mask` is 0 and `vec_req` is low.
- R2: Addresses 0 to 5 are read/write: 0 enables sources 0-6 (bits 0-6) plus the global enable (bit 7); 1 enables sources 8-15; 2/3 hold the high/low level bits of sources 0-7; 4/5 hold the high/low level bits of sources 8-15. Addresses 6 and 7 return the pending flags of sources 0-7 and 8-15, and writes to them change nothing.
- R3: A 0-to-1 transition of `irq_in[i]` sets pending flag i. The flag stays set after the line drops. A line held high does not set the flag again once it has been cleared.
- R4: A pending source can be requested only while the global enable is set and its own enable bit is set. Source 7 has no bit of its own and follows the global enable. A disabled source keeps its pending flag.
- R5: A source's level is {high bit, low bit}: 00 is level 0 (lowest) and 11 is level 3 (highest). Among eligible sources the highest level wins.
- R6: Among eligible sources at the winning level, the lowest source index wins.
- R7: While a level is in service, only sources with a strictly higher level are requested. Sources of equal or lower level wait.
- R8: Nothing is dispatched until `insn_done` is high while `vec_req` is high. On that edge the winner's pending flag clears and bit `vec_lvl` of `svc_mask` sets.
- R9: A `reti` pulse clears the highest set bit of `svc_mask`. Waiting lower-level sources are then requested.
- R10: `vec_addr` equals VEC_BASE + VEC_STRIDE * `vec_idx`. The defaults are 3 and 8.
- R11: A `reti` pulse while `svc_mask` is zero leaves all state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 16 | Interrupt request lines, one per source |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| insn_done | input | 1 | Core has completed its current instruction |
| reti | input | 1 | Core return-from-interrupt pulse |
| vec_req | output | 1 | Vector request to the core |
| vec_idx | output | 4 | Index of the requested source |
| vec_lvl | output | 2 | Level of the requested source |
| vec_addr | output | 16 | Handler address of the requested source |
| svc_mask | output | 4 | In-service mask, one bit per level |

## Verification
The hardest situation to reach is a three-deep chain: a level-2 handler is preempted by a level-3 source while a level-1 source sits pending underneath. The two returns must then unwind the chain in order. The stimulus builds this chain by accepting the level-2 source first, then raising the level-1 line, whose request must stay silent, and only then raising the level-3 line. Each `reti` is followed by a check of the mask and of which source, if any, is being requested. Ties are created by raising two lines on the same cycle. Preservation of a disabled pending flag is read back through the pending address.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned NUM_SRC    = 16;
  localparam int unsigned NUM_LVL    = 4;
  localparam int unsigned REG_W      = 8;
  localparam int unsigned SRC_W      = $clog2(NUM_SRC);
  localparam int unsigned LVL_W      = $clog2(NUM_LVL);
  localparam int unsigned BANKS      = NUM_SRC / REG_W;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned GLOBAL_BIT = REG_W - 1;

  typedef logic [SRC_W-1:0] src_idx_t;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic [ADDR_W-1:0] {
    A_EN_A  = 3'd0,
    A_EN_B  = 3'd1,
    A_PH_A  = 3'd2,
    A_PL_A  = 3'd3,
    A_PH_B  = 3'd4,
    A_PL_B  = 3'd5,
    A_PND_A = 3'd6,
    A_PND_B = 3'd7
  } cfg_addr_e;

  typedef struct packed {
    logic     valid;
    src_idx_t idx;
    lvl_t     lvl;
  } grant_t;
endpackage

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [REG_W-1:0]               wdata,
  input  logic [NUM_SRC-1:0]             pend,
  output logic [REG_W-1:0]               rdata,
  output logic [NUM_SRC-1:0]             src_en,
  output logic                           glb_en,
  output logic [NUM_SRC-1:0][LVL_W-1:0]  src_lvl
);

  logic [BANKS-1:0][REG_W-1:0] en_q, en_d;
  logic [BANKS-1:0][REG_W-1:0] ph_q, ph_d;
  logic [BANKS-1:0][REG_W-1:0] pl_q, pl_d;

  always_comb begin
    en_d = en_q;
    ph_d = ph_q;
    pl_d = pl_q;
    if (we) begin
      case (cfg_addr_e'(addr))
        A_EN_A:  en_d[0] = wdata;
        A_EN_B:  en_d[1] = wdata;
        A_PH_A:  ph_d[0] = wdata;
        A_PL_A:  pl_d[0] = wdata;
        A_PH_B:  ph_d[1] = wdata;
        A_PL_B:  pl_d[1] = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      ph_q <= '0;
      pl_q <= '0;
    end else if (we) begin
      en_q <= en_d;
      ph_q <= ph_d;
      pl_q <= pl_d;
    end
  end

  always_comb begin
    case (cfg_addr_e'(addr))
      A_EN_A:  rdata = en_q[0];
      A_EN_B:  rdata = en_q[1];
      A_PH_A:  rdata = ph_q[0];
      A_PL_A:  rdata = pl_q[0];
      A_PH_B:  rdata = ph_q[1];
      A_PL_B:  rdata = pl_q[1];
      A_PND_A: rdata = pend[REG_W-1:0];
      A_PND_B: rdata = pend[NUM_SRC-1:REG_W];
      default: rdata = '0;
    endcase
  end

  assign glb_en = en_q[0][GLOBAL_BIT];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int unsigned B = s / REG_W;
    localparam int unsigned K = s % REG_W;
    if (B == 0 && K == GLOBAL_BIT) begin : g_glb
      assign src_en[s] = 1'b1;
    end else begin : g_own
      assign src_en[s] = en_q[B][K];
    end
    assign src_lvl[s] = {ph_q[B][K], pl_q[B][K]};
  end

  // R2: writes to the pending addresses leave the configuration untouched
  a_r2_pend_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    we && (addr >= A_PND_A) |=> $stable(en_q) && $stable(ph_q) && $stable(pl_q));

endmodule

// File: rtl/nic_pending.sv
module nic_pending #(
  parameter int unsigned N   = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  pend
);

  logic [N-1:0] irq_d_q;
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] rise;
  logic [N-1:0] clr_vec;

  assign rise    = irq & ~irq_d_q;
  assign clr_vec = clr_en ? ({{(N-1){1'b0}}, 1'b1} << clr_idx) : '0;

  always_comb begin
    pend_d = (pend_q & ~clr_vec) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_d_q <= '0;
      pend_q  <= '0;
    end else begin
      irq_d_q <= irq;
      pend_q  <= pend_d;
    end
  end

  assign pend = pend_q;

  // R3: a pending flag only falls when it was the accepted source
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~pend_q) & ~$past(clr_vec)) == '0));

  // R8: the accepted source's flag is gone after the accept edge
  a_r8_clear_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && !rise[clr_idx] |=> !pend_q[$past(clr_idx)]);

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             req,
  input  logic [NUM_SRC-1:0][LVL_W-1:0]  src_lvl,
  input  logic                           cur_act,
  input  lvl_t                           cur_lvl,
  output grant_t                         win
);

  logic [NUM_LVL-1:0][NUM_SRC-1:0] lvl_mask;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    logic lvl_ok;
    assign lvl_ok = !cur_act || (lvl_t'(l) > cur_lvl);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_s
      assign lvl_mask[l][s] = req[s] && (src_lvl[s] == lvl_t'(l)) && lvl_ok;
    end
  end

  always_comb begin
    win = '0;
    for (int l = NUM_LVL - 1; l >= 0; l--) begin
      if (!win.valid && (|lvl_mask[l])) begin
        win.valid = 1'b1;
        win.lvl   = lvl_t'(l);
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
          if (lvl_mask[l][s]) win.idx = src_idx_t'(s);
        end
      end
    end
  end

  // R7: a grant always outranks the level in service
  a_r7_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
    win.valid && cur_act |-> win.lvl > cur_lvl);

  // R5: the granted source is a live request at the reported level
  a_r5_grant_is_request: assert property (@(posedge clk) disable iff (!rst_n)
    win.valid |-> req[win.idx] && (src_lvl[win.idx] == win.lvl));

endmodule

// File: rtl/nic_isr_stack.sv
module nic_isr_stack
  import nic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  lvl_t               push_lvl,
  input  logic               pop,
  output logic [NUM_LVL-1:0] svc_mask,
  output logic               cur_act,
  output lvl_t               cur_lvl
);

  logic [NUM_LVL-1:0] svc_q, svc_d;
  logic [NUM_LVL-1:0] top_bit;
  logic [NUM_LVL-1:0] push_bit;

  always_comb begin
    cur_act = |svc_q;
    cur_lvl = '0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (svc_q[l]) cur_lvl = lvl_t'(l);
    end
  end

  assign top_bit  = cur_act ? ({{(NUM_LVL-1){1'b0}}, 1'b1} << cur_lvl) : '0;
  assign push_bit = {{(NUM_LVL-1){1'b0}}, 1'b1} << push_lvl;

  always_comb begin
    svc_d = svc_q;
    if (pop)  svc_d = svc_d & ~top_bit;
    if (push) svc_d = svc_d | push_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          svc_q <= '0;
    else if (push || pop) svc_q <= svc_d;
  end

  assign svc_mask = svc_q;

  // R8: an accepted level is in service on the next cycle
  a_r8_mark_level: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> svc_q[$past(push_lvl)]);

  // R9: a return drops the level that was running
  a_r9_pop_top: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && cur_act |=> !svc_q[$past(cur_lvl)]);

  // R11: a return with nothing in service changes nothing
  a_r11_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push && !cur_act |=> svc_q == '0);

  // R7: nesting only goes upward
  a_r7_push_above: assert property (@(posedge clk) disable iff (!rst_n)
    push && cur_act |-> push_lvl > cur_lvl);

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned VADDR_W    = 16,
  parameter logic [VADDR_W-1:0] VEC_BASE = 16'h0003,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic                insn_done,
  input  logic                reti,
  output logic                vec_req,
  output logic [SRC_W-1:0]    vec_idx,
  output logic [LVL_W-1:0]    vec_lvl,
  output logic [VADDR_W-1:0]  vec_addr,
  output logic [NUM_LVL-1:0]  svc_mask
);

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [NUM_SRC-1:0]            pend;
  logic [NUM_SRC-1:0]            src_en;
  logic                          glb_en;
  logic [NUM_SRC-1:0][LVL_W-1:0] src_lvl;
  logic [NUM_SRC-1:0]            req;
  logic                          cur_act;
  lvl_t                          cur_lvl;
  grant_t                        win;
  logic                          accept;

  nic_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .pend    (pend),
    .rdata   (cfg_rdata),
    .src_en  (src_en),
    .glb_en  (glb_en),
    .src_lvl (src_lvl)
  );

  nic_pending #(.N(NUM_SRC)) u_pend (
    .clk     (clk),
    .rst_n   (rst_sn),
    .irq     (irq_in),
    .clr_en  (accept),
    .clr_idx (win.idx),
    .pend    (pend)
  );

  assign req = pend & src_en & {NUM_SRC{glb_en}};

  nic_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_sn),
    .req     (req),
    .src_lvl (src_lvl),
    .cur_act (cur_act),
    .cur_lvl (cur_lvl),
    .win     (win)
  );

  assign accept = win.valid && insn_done;

  nic_isr_stack u_isr (
    .clk      (clk),
    .rst_n    (rst_sn),
    .push     (accept),
    .push_lvl (win.lvl),
    .pop      (reti),
    .svc_mask (svc_mask),
    .cur_act  (cur_act),
    .cur_lvl  (cur_lvl)
  );

  assign vec_req  = win.valid;
  assign vec_idx  = win.idx;
  assign vec_lvl  = win.lvl;
  assign vec_addr = VEC_BASE + VADDR_W'(VEC_STRIDE) * VADDR_W'(win.idx);

  // R4: a request needs the global enable, the source enable and its flag
  a_r4_gated_request: assert property (@(posedge clk) disable iff (!rst_sn)
    vec_req |-> glb_en && src_en[vec_idx] && pend[vec_idx]);

  // R8: without completion nothing is dispatched and the mask holds
  a_r8_wait_done: assert property (@(posedge clk) disable iff (!rst_sn)
    !insn_done && !reti |=> $stable(svc_mask));

endmodule

// File: tb/sim_nest_irq_ctrl.sv
module sim_nest_irq_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        insn_done;
  logic        reti;
  logic        vec_req;
  logic [3:0]  vec_idx;
  logic [1:0]  vec_lvl;
  logic [15:0] vec_addr;
  logic [3:0]  svc_mask;

  always #(CLK_PERIOD/2) clk = ~clk;

  nest_irq_ctrl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .insn_done (insn_done),
    .reti      (reti),
    .vec_req   (vec_req),
    .vec_idx   (vec_idx),
    .vec_lvl   (vec_lvl),
    .vec_addr  (vec_addr),
    .svc_mask  (svc_mask)
  );

  typedef struct {
    int    idx;
    int    lvl;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur_e;
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;
  bit   done   = 1'b0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    cfg_we    = 1'b1;
    cfg_addr  = 3'(a);
    cfg_wdata = 8'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    cfg_addr = 3'(a);
    #1;
    chk(tag, $sformatf("read addr %0d", a), int'(cfg_rdata), exp);
  endtask

  task automatic pulse(int mask);
    irq_in = irq_in | 16'(mask);
    @(negedge clk);
    irq_in = irq_in & ~16'(mask);
  endtask

  task automatic ret();
    reti = 1'b1;
    @(negedge clk);
    reti = 1'b0;
  endtask

  // driver: announce the expected vector, then let the core accept it
  task automatic take(int idx, int lvl, string tag);
    exp_t e;
    e.idx = idx;
    e.lvl = lvl;
    e.tag = tag;
    exp_q.push_back(e);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
  endtask

  // monitor: every accepted vector is popped and compared (R10 for address)
  always @(negedge clk) begin
    #4;
    if (mon_on && vec_req && insn_done) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL R8 unexpected accept: actual idx %0d expected none", vec_idx);
      end else begin
        cur_e = exp_q.pop_front();
        chk(cur_e.tag, "vec_idx", int'(vec_idx), cur_e.idx);
        chk(cur_e.tag, "vec_lvl", int'(vec_lvl), cur_e.lvl);
        chk("R10", "vec_addr", int'(vec_addr), 3 + 8 * cur_e.idx);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_in = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    insn_done = 1'b0; reti = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) rd_chk("R1", a, 0);
    chk("R1", "vec_req", int'(vec_req), 0);
    chk("R1", "svc_mask", int'(svc_mask), 0);

    // R2 register readback and read-only pending addresses
    for (int a = 0; a < 6; a++) wr(a, 8'h11 * (a + 1));
    for (int a = 0; a < 6; a++) rd_chk("R2", a, (8'h11 * (a + 1)) & 8'hff);
    for (int a = 0; a < 6; a++) wr(a, 0);
    wr(6, 8'hff);
    wr(7, 8'hff);
    rd_chk("R2", 6, 0);
    rd_chk("R2", 7, 0);
    rd_chk("R2", 0, 0);
    @(negedge clk);

    // R3 latch with the line held high; R4 gating
    irq_in[3] = 1'b1;
    @(negedge clk);
    rd_chk("R3", 6, 8'h08);
    chk("R4", "vec_req no enable", int'(vec_req), 0);
    @(negedge clk);
    wr(0, 8'h08);
    chk("R4", "vec_req no global", int'(vec_req), 0);
    wr(0, 8'h88);
    chk("R4", "vec_req enabled", int'(vec_req), 1);
    chk("R4", "vec_idx", int'(vec_idx), 3);
    take(3, 0, "R8");
    chk("R8", "svc_mask", int'(svc_mask), 1);
    rd_chk("R8", 6, 0);
    repeat (3) @(negedge clk);
    rd_chk("R3", 6, 0);
    irq_in[3] = 1'b0;
    @(negedge clk);
    ret();
    chk("R9", "svc_mask", int'(svc_mask), 0);

    // R6 tie at level 1, R8 waiting, R7 equal level blocked
    wr(3, 8'h24);
    wr(0, 8'ha4);
    pulse((1 << 2) | (1 << 5));
    chk("R6", "vec_idx", int'(vec_idx), 2);
    chk("R6", "vec_lvl", int'(vec_lvl), 1);
    repeat (3) @(negedge clk);
    chk("R8", "vec_req held", int'(vec_req), 1);
    chk("R8", "svc_mask idle", int'(svc_mask), 0);
    rd_chk("R8", 6, 8'h24);
    @(negedge clk);
    take(2, 1, "R6");
    chk("R8", "svc_mask", int'(svc_mask), 2);
    chk("R7", "equal level blocked", int'(vec_req), 0);
    ret();
    chk("R9", "vec_req after reti", int'(vec_req), 1);
    chk("R9", "vec_idx after reti", int'(vec_idx), 5);
    take(5, 1, "R9");
    ret();
    chk("R9", "svc_mask", int'(svc_mask), 0);

    // R7 / R9 three-deep nesting: src12 level 2, src9 level 3, src2 level 1
    wr(4, 8'h12);
    wr(5, 8'h02);
    wr(1, 8'h12);
    pulse(1 << 12);
    take(12, 2, "R5");
    chk("R8", "svc_mask", int'(svc_mask), 4);
    pulse(1 << 2);
    chk("R7", "lower level blocked", int'(vec_req), 0);
    pulse(1 << 9);
    chk("R7", "higher level preempts", int'(vec_req), 1);
    chk("R7", "vec_idx", int'(vec_idx), 9);
    take(9, 3, "R7");
    chk("R8", "svc_mask", int'(svc_mask), 12);
    ret();
    chk("R9", "svc_mask", int'(svc_mask), 4);
    chk("R9", "still blocked", int'(vec_req), 0);
    ret();
    chk("R9", "svc_mask", int'(svc_mask), 0);
    chk("R9", "vec_idx", int'(vec_idx), 2);
    take(2, 1, "R9");
    ret();

    // R5 highest level wins over a lower index
    pulse((1 << 2) | (1 << 9));
    chk("R5", "vec_idx", int'(vec_idx), 9);
    take(9, 3, "R5");
    chk("R7", "lower waits", int'(vec_req), 0);
    ret();
    take(2, 1, "R5");
    ret();

    // R4 source 7 follows the global enable
    pulse(1 << 7);
    chk("R4", "src7 vec_idx", int'(vec_idx), 7);
    take(7, 0, "R4");
    ret();

    // R4 disabled source keeps its flag
    wr(0, 8'h24);
    pulse(1 << 5);
    chk("R4", "global off", int'(vec_req), 0);
    rd_chk("R4", 6, 8'h20);
    @(negedge clk);
    wr(0, 8'ha4);
    chk("R4", "re-enabled vec_idx", int'(vec_idx), 5);
    take(5, 1, "R4");
    ret();

    // R11 return with empty mask
    ret();
    chk("R11", "svc_mask", int'(svc_mask), 0);
    chk("R11", "vec_req", int'(vec_req), 0);
    pulse(1 << 12);
    take(12, 2, "R11");
    chk("R11", "svc_mask after", int'(svc_mask), 4);
    ret();

    repeat (2) @(negedge clk);
    chk("R8", "unconsumed expectations", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule